// File: doc/BRIEF.md
# Interrupt Entry and Return State Swap

This block decides whether a 32-bit processor core takes an interrupt at the next instruction boundary, and performs the architectural state swap when it does. It looks at a 16-line enable mask, the matching 16-line request flags, a global enable bit and the live status word. An entry banks a return link (next instruction address plus 4) and a copy of the status word, emits a fixed interrupt-mode status word and redirects fetch to the interrupt vector.

A return request goes the other way. The banked saved-status word is emitted as the new status word, the four condition flags are unpacked from its top nibble and the processor mode is taken from its low five bits. The status register itself lives in the core: the block drives a one-cycle load strobe with the new value, and the core feeds the current word back on `statusIn`. Every result is registered, so it appears in the cycle after the request is sampled.

Top module: `irq_switch_ctrl`

## Requirements
- R1: After reset every output is zero.
- R2: An entry is taken only in a cycle where `stepStrobe` is 1, `intEnable & intFlags` is nonzero, `masterEn` is 1, `statusIn` bit 7 (interrupt mask) is 0 and `retReq` is 0. In any other cycle `fetchRedirect` stays 0 and `linkReg` and `savedStatus` keep their values.
- R3: In the cycle after an entry, `linkReg` equals the sampled `nextPc` plus 4, modulo 2^32.
- R4: In the cycle after an entry, `savedStatus` equals the sampled `statusIn`.
- R5: In the cycle after an entry, `statusWe` is 1, `statusOut` is 32'h000000D2, `modeOut` is 5'h12 and the four flags are 0.
- R6: In the cycle after an entry, `fetchRedirect` is 1 and `fetchAddr` is 32'h00000018. `fetchRedirect` is a one-cycle pulse.
- R7: In the cycle after `retReq` is sampled, `statusWe` is 1, `statusOut` equals `savedStatus`, `flagN`, `flagZ`, `flagC` and `flagV` equal bits 31, 30, 29 and 28 of it, and `modeOut` equals its bits 4:0. `fetchRedirect` stays 0, and `linkReg` and `savedStatus` are unchanged.
- R8: When `retReq` and a qualifying entry occur in the same cycle, only the return is performed as in R7.
- R9: In a cycle with no entry and no return, `statusWe` returns to 0 and `statusOut`, the flags, `modeOut` and `fetchAddr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intEnable | input | 16 | Per-line interrupt enable mask |
| intFlags | input | 16 | Per-line interrupt request flags |
| masterEn | input | 1 | Global interrupt enable |
| stepStrobe | input | 1 | Instruction boundary; entry is considered only here |
| nextPc | input | 32 | Address of the next instruction |
| retReq | input | 1 | Request to return from the interrupt handler |
| statusIn | input | 32 | Current status word from the core |
| statusWe | output | 1 | One-cycle strobe: load `statusOut` into the status register |
| statusOut | output | 32 | New status word |
| flagN | output | 1 | Negative flag, status bit 31 |
| flagZ | output | 1 | Zero flag, status bit 30 |
| flagC | output | 1 | Carry flag, status bit 29 |
| flagV | output | 1 | Overflow flag, status bit 28 |
| modeOut | output | 5 | Processor mode, status bits 4:0 |
| fetchRedirect | output | 1 | One-cycle strobe: restart fetch at `fetchAddr` |
| fetchAddr | output | 32 | Fetch target (interrupt vector) |
| linkReg | output | 32 | Banked interrupt return link |
| savedStatus | output | 32 | Banked interrupt saved-status word |

## Verification
An interrupt entry and a handler return can both be asked for in the same cycle. The bench provokes this by raising `retReq` on a boundary cycle in which all entry conditions hold. In the next cycle it expects no fetch redirect, a status load taken from the banked saved status with matching flags and mode, and unchanged link and saved-status registers. A following return on its own confirms that the banked state survived the collision.

// File: rtl/irq_switch_pkg.sv
package irq_switch_pkg;

  // Strobes from the control to the datapath; at most one is set.
  typedef struct packed {
    logic doEntry;
    logic doReturn;
  } swapStrobe_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } condFlags_t;

  // Top nibble of a status word, most significant bit first: N Z C V.
  function automatic condFlags_t unpackFlags(input logic [3:0] nib);
    condFlags_t f;
    f.n = nib[3];
    f.z = nib[2];
    f.c = nib[1];
    f.v = nib[0];
    return f;
  endfunction

endpackage

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_switch_pkg::*;
#(
  parameter int SRC_COUNT = 16
) (
  input  logic [SRC_COUNT-1:0] intEnable,
  input  logic [SRC_COUNT-1:0] intFlags,
  input  logic                 masterEn,
  input  logic                 irqMasked,
  input  logic                 stepStrobe,
  input  logic                 retReq,
  output swapStrobe_t          strb
);

  logic anyLine;
  logic pending;

  always_comb begin
    anyLine = |(intEnable & intFlags);
    pending = anyLine && masterEn && !irqMasked;
    // A return always wins; a blocked entry is re-evaluated at the next boundary.
    strb.doReturn = retReq;
    strb.doEntry  = stepStrobe && pending && !retReq;
  end

endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_switch_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter int          MODE_W       = 5,
  parameter int          LINK_OFFSET  = 4,
  parameter logic [31:0] ENTRY_STATUS = 32'h0000_00D2,
  parameter logic [31:0] IRQ_VECTOR   = 32'h0000_0018
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapStrobe_t       strb,
  input  logic [DATA_W-1:0] nextPc,
  input  logic [DATA_W-1:0] statusIn,
  output logic              statusWe,
  output logic [DATA_W-1:0] statusOut,
  output condFlags_t        flags,
  output logic [MODE_W-1:0] modeOut,
  output logic              fetchRedirect,
  output logic [DATA_W-1:0] fetchAddr,
  output logic [DATA_W-1:0] linkReg,
  output logic [DATA_W-1:0] savedStatus
);

  localparam int FLAG_LO = DATA_W - 4;
  localparam logic [DATA_W-1:0] ENTRY_WORD = DATA_W'(ENTRY_STATUS);
  localparam logic [DATA_W-1:0] VEC_WORD   = DATA_W'(IRQ_VECTOR);
  localparam logic [DATA_W-1:0] LINK_ADD   = DATA_W'(LINK_OFFSET);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWe      <= 1'b0;
      statusOut     <= '0;
      flags         <= '0;
      modeOut       <= '0;
      fetchRedirect <= 1'b0;
      fetchAddr     <= '0;
      linkReg       <= '0;
      savedStatus   <= '0;
    end else begin
      statusWe      <= 1'b0;
      fetchRedirect <= 1'b0;
      if (strb.doReturn) begin
        statusWe  <= 1'b1;
        statusOut <= savedStatus;
        flags     <= unpackFlags(savedStatus[DATA_W-1:FLAG_LO]);
        modeOut   <= savedStatus[MODE_W-1:0];
      end else if (strb.doEntry) begin
        linkReg       <= nextPc + LINK_ADD;
        savedStatus   <= statusIn;
        statusWe      <= 1'b1;
        statusOut     <= ENTRY_WORD;
        flags         <= unpackFlags(ENTRY_WORD[DATA_W-1:FLAG_LO]);
        modeOut       <= ENTRY_WORD[MODE_W-1:0];
        fetchRedirect <= 1'b1;
        fetchAddr     <= VEC_WORD;
      end
    end
  end

endmodule

// File: rtl/irq_switch_ctrl.sv
module irq_switch_ctrl
  import irq_switch_pkg::*;
#(
  parameter int          SRC_COUNT    = 16,
  parameter int          DATA_W       = 32,
  parameter int          MODE_W       = 5,
  parameter int          MASK_BIT     = 7,
  parameter int          LINK_OFFSET  = 4,
  parameter logic [31:0] ENTRY_STATUS = 32'h0000_00D2,
  parameter logic [31:0] IRQ_VECTOR   = 32'h0000_0018
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] intEnable,
  input  logic [SRC_COUNT-1:0] intFlags,
  input  logic                 masterEn,
  input  logic                 stepStrobe,
  input  logic [DATA_W-1:0]    nextPc,
  input  logic                 retReq,
  input  logic [DATA_W-1:0]    statusIn,
  output logic                 statusWe,
  output logic [DATA_W-1:0]    statusOut,
  output logic                 flagN,
  output logic                 flagZ,
  output logic                 flagC,
  output logic                 flagV,
  output logic [MODE_W-1:0]    modeOut,
  output logic                 fetchRedirect,
  output logic [DATA_W-1:0]    fetchAddr,
  output logic [DATA_W-1:0]    linkReg,
  output logic [DATA_W-1:0]    savedStatus
);

  swapStrobe_t strb;
  condFlags_t  flags;

  irq_gate_ctrl #(.SRC_COUNT(SRC_COUNT)) uCtrl (
    .intEnable (intEnable),
    .intFlags  (intFlags),
    .masterEn  (masterEn),
    .irqMasked (statusIn[MASK_BIT]),
    .stepStrobe(stepStrobe),
    .retReq    (retReq),
    .strb      (strb)
  );

  irq_bank_dp #(
    .DATA_W      (DATA_W),
    .MODE_W      (MODE_W),
    .LINK_OFFSET (LINK_OFFSET),
    .ENTRY_STATUS(ENTRY_STATUS),
    .IRQ_VECTOR  (IRQ_VECTOR)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .nextPc       (nextPc),
    .statusIn     (statusIn),
    .statusWe     (statusWe),
    .statusOut    (statusOut),
    .flags        (flags),
    .modeOut      (modeOut),
    .fetchRedirect(fetchRedirect),
    .fetchAddr    (fetchAddr),
    .linkReg      (linkReg),
    .savedStatus  (savedStatus)
  );

  assign flagN = flags.n;
  assign flagZ = flags.z;
  assign flagC = flags.c;
  assign flagV = flags.v;

endmodule

// File: rtl/irq_switch_checker.sv
module irq_switch_checker #(
  parameter int          SRC_COUNT    = 16,
  parameter int          DATA_W       = 32,
  parameter int          MODE_W       = 5,
  parameter int          MASK_BIT     = 7,
  parameter int          LINK_OFFSET  = 4,
  parameter logic [31:0] ENTRY_STATUS = 32'h0000_00D2,
  parameter logic [31:0] IRQ_VECTOR   = 32'h0000_0018
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [SRC_COUNT-1:0] intEnable,
  input logic [SRC_COUNT-1:0] intFlags,
  input logic                 masterEn,
  input logic                 stepStrobe,
  input logic [DATA_W-1:0]    nextPc,
  input logic                 retReq,
  input logic [DATA_W-1:0]    statusIn,
  input logic                 statusWe,
  input logic [DATA_W-1:0]    statusOut,
  input logic                 flagN,
  input logic                 flagZ,
  input logic                 flagC,
  input logic                 flagV,
  input logic [MODE_W-1:0]    modeOut,
  input logic                 fetchRedirect,
  input logic [DATA_W-1:0]    fetchAddr,
  input logic [DATA_W-1:0]    linkReg,
  input logic [DATA_W-1:0]    savedStatus
);

  localparam logic [DATA_W-1:0] ENTRY_WORD = DATA_W'(ENTRY_STATUS);
  localparam logic [DATA_W-1:0] VEC_WORD   = DATA_W'(IRQ_VECTOR);
  localparam logic [DATA_W-1:0] LINK_ADD   = DATA_W'(LINK_OFFSET);

  logic wantEntry;
  assign wantEntry = stepStrobe && (|(intEnable & intFlags)) && masterEn
                     && !statusIn[MASK_BIT] && !retReq;

  assert_entry_link_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(wantEntry) |-> (linkReg == $past(nextPc) + LINK_ADD) && fetchRedirect);

  assert_entry_saved_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(wantEntry) |-> savedStatus == $past(statusIn));

  assert_vector_R6: assert property (@(posedge clk) disable iff (!rstN)
    fetchRedirect |-> (fetchAddr == VEC_WORD) && (statusOut == ENTRY_WORD)
                      && statusWe && (modeOut == ENTRY_WORD[MODE_W-1:0]));

  assert_no_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stepStrobe) |-> !fetchRedirect);

  assert_return_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(retReq) |-> !fetchRedirect && statusWe && (statusOut == savedStatus)
                      && $stable(linkReg));

  assert_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusWe |-> ({flagN, flagZ, flagC, flagV} == statusOut[DATA_W-1:DATA_W-4])
                 && (modeOut == statusOut[MODE_W-1:0]));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !statusWe |-> $stable(statusOut) && $stable(modeOut) && $stable(fetchAddr));

endmodule

bind irq_switch_ctrl irq_switch_checker #(
  .SRC_COUNT(SRC_COUNT), .DATA_W(DATA_W), .MODE_W(MODE_W), .MASK_BIT(MASK_BIT),
  .LINK_OFFSET(LINK_OFFSET), .ENTRY_STATUS(ENTRY_STATUS), .IRQ_VECTOR(IRQ_VECTOR)
) uChk (
  .clk(clk), .rstN(rstN), .intEnable(intEnable), .intFlags(intFlags),
  .masterEn(masterEn), .stepStrobe(stepStrobe), .nextPc(nextPc), .retReq(retReq),
  .statusIn(statusIn), .statusWe(statusWe), .statusOut(statusOut),
  .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV), .modeOut(modeOut),
  .fetchRedirect(fetchRedirect), .fetchAddr(fetchAddr), .linkReg(linkReg),
  .savedStatus(savedStatus)
);

// File: tb/tb_irq_switch_ctrl.sv
`timescale 1ns/100ps
module tb_irq_switch_ctrl;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] intEnable, intFlags;
  logic        masterEn, stepStrobe, retReq;
  logic [31:0] nextPc, statusIn;
  logic        statusWe, flagN, flagZ, flagC, flagV, fetchRedirect;
  logic [31:0] statusOut, fetchAddr, linkReg, savedStatus;
  logic [4:0]  modeOut;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  irq_switch_ctrl dut (
    .clk(clk), .rstN(rstN), .intEnable(intEnable), .intFlags(intFlags),
    .masterEn(masterEn), .stepStrobe(stepStrobe), .nextPc(nextPc), .retReq(retReq),
    .statusIn(statusIn), .statusWe(statusWe), .statusOut(statusOut),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV), .modeOut(modeOut),
    .fetchRedirect(fetchRedirect), .fetchAddr(fetchAddr), .linkReg(linkReg),
    .savedStatus(savedStatus)
  );

  // Output bundle: we, status, NZCV, mode, redirect, fetch, link, saved = 139 bits.
  function automatic logic [138:0] observed();
    return {statusWe, statusOut, flagN, flagZ, flagC, flagV, modeOut,
            fetchRedirect, fetchAddr, linkReg, savedStatus};
  endfunction

  logic [138:0] expQ[$];
  string        tagQ[$];

  // Reference state derived from the requirements.
  logic [31:0] mStatus = '0, mFetch = '0, mLink = '0, mSaved = '0;
  logic [3:0]  mFlags = '0;
  logic [4:0]  mMode = '0;

  task automatic step(input string tag, input logic [15:0] en, input logic [15:0] fl,
                      input logic me, input logic stb, input logic ret,
                      input logic [31:0] st, input logic [31:0] pc);
    logic take;
    logic we, redir;
    @(negedge clk);
    intEnable = en; intFlags = fl; masterEn = me; stepStrobe = stb;
    retReq = ret; statusIn = st; nextPc = pc;
    take = stb && ((en & fl) != 16'h0) && me && !st[7] && !ret;
    we = 1'b0; redir = 1'b0;
    if (ret) begin
      we = 1'b1; mStatus = mSaved; mFlags = mSaved[31:28]; mMode = mSaved[4:0];
    end else if (take) begin
      mLink = pc + 32'd4; mSaved = st; we = 1'b1; mStatus = 32'h0000_00D2;
      mFlags = 4'h0; mMode = 5'h12; redir = 1'b1; mFetch = 32'h0000_0018;
    end
    expQ.push_back({we, mStatus, mFlags, mMode, redir, mFetch, mLink, mSaved});
    tagQ.push_back(tag);
  endtask

  // Monitor: compares one cycle after each driven cycle, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [138:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (observed() !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, observed(), e);
        end
      end
    end
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; intEnable = '0; intFlags = '0; masterEn = 1'b0; stepStrobe = 1'b0;
    retReq = 1'b0; statusIn = '0; nextPc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checks++;
    if (observed() !== '0) begin
      errors++;
      $display("FAIL R1 actual=%h expected=0", observed());
    end

    step("R2 no strobe", 16'h0001, 16'h0001, 1, 0, 0, 32'h0000_001F, 32'h100);
    step("R2 master off", 16'h0001, 16'h0001, 0, 1, 0, 32'h0000_001F, 32'h104);
    step("R2 disjoint lines", 16'h00F0, 16'h000F, 1, 1, 0, 32'h0000_001F, 32'h108);
    step("R2 masked bit7", 16'h0001, 16'h0001, 1, 1, 0, 32'h0000_0080, 32'h10C);
    step("R3 R4 R5 R6 entry", 16'h0001, 16'h0001, 1, 1, 0, 32'hF000_001F, 32'h0800_1000);
    step("R9 hold", 16'h0000, 16'h0000, 1, 0, 0, 32'h0000_00D2, 32'h0800_1004);
    step("R2 masked in handler", 16'h0001, 16'h0001, 1, 1, 0, 32'h0000_00D2, 32'h18);
    step("R7 return", 16'h0001, 16'h0001, 1, 0, 1, 32'h0000_00D2, 32'h1C);
    step("R9 after return", 16'h0000, 16'h0000, 0, 0, 0, 32'hF000_001F, 32'h0800_1004);
    step("R3 wrap entry", 16'h8000, 16'hFFFF, 1, 1, 0, 32'h6000_0010, 32'hFFFF_FFFC);
    step("R8 return beats entry", 16'h0004, 16'h0004, 1, 1, 1, 32'h0000_0013, 32'h200);
    step("R7 return again", 16'h0000, 16'h0000, 0, 0, 1, 32'h0000_00D2, 32'h204);
    step("R5 R6 entry high line", 16'h8000, 16'h8000, 1, 1, 0, 32'h9000_0050, 32'h300);
    step("R9 idle", 16'h0000, 16'h0000, 0, 0, 0, 32'h0000_00D2, 32'h304);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule